// File: doc/BRIEF.md
# Centre-Aligned Complementary PWM Pair

This block drives one high-side / low-side PWM pair for a motor bridge from a triangular counter. The counter climbs from 0 to a period value, falls back to 0 and repeats, so one PWM cycle takes twice the period value in clock cycles. The high-side output is set and cleared by compare events taken in different counting directions, which gives pulses that straddle the counter peak.

There are two modes. In dual-compare mode the high-side compare value sets the edge that turns the output on while the counter rises. The low-side compare value sets the edge that turns it off while the counter falls, so the pulse can sit off centre. In centred mode only the high-side compare value is used, for both edges, and the pulse is symmetric about the peak. While the run control is high, the low-side output is the inverse of the high-side output. The period, both compare values and the mode are captured into shadow registers only at the counter's zero point, so software may write them at any time without producing a broken pulse.

Top module: `cpwm_pair`

## Requirements
- R1: While `rst_ni` is low, and after it is released with `start_i` low, `cnt_o` is 0, `cnt_up_o` is 1, and both `pwm_hi_o` and `pwm_lo_o` are 0.
- R2: While running with a captured period P > 0, `cnt_o` follows 0,1,...,P,P-1,...,1 and repeats every 2P cycles. `cnt_up_o` is 1 for the values 0..P on the way up and 0 for P-1..1 on the way down. With P = 0 the counter stays at 0.
- R3: In dual-compare mode (`mode_i` = 0), `pwm_hi_o` goes to 1 in the cycle after the rising counter equals the captured high-side compare value H.
- R4: In dual-compare mode, `pwm_hi_o` returns to 0 in the cycle after the falling counter equals the captured low-side compare value L.
- R5: In centred mode (`mode_i` = 1), `pwm_hi_o` rises in the cycle after the rising counter equals H and falls in the cycle after the falling counter equals H. `duty_lo_i` has no effect in this mode.
- R6: In the cycles after `start_i` is sampled high, `pwm_lo_o` equals the inverse of `pwm_hi_o`. Right after start it is therefore 1.
- R7: Period, H, L and mode are captured when `cnt_o` is 0 (and every cycle while stopped). A change at any other time takes effect only after the counter next reaches 0.
- R8: A compare value that is in use and equals 0 or is not less than P keeps `pwm_hi_o` at 0 for the whole cycle. In dual-compare mode this applies to H or L; in centred mode it applies to H.
- R9: One cycle after `start_i` is sampled low, `cnt_o` is 0, `cnt_up_o` is 1, and both outputs are 0. They stay there until `start_i` rises again, and restarting begins a fresh cycle from 0.
- R10: `pwm_hi_o` is 0 whenever `cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run control; low holds the counter at 0 and both outputs low |
| mode_i | input | 1 | 0 = dual-compare, 1 = centred |
| period_i | input | CNT_W | Counter peak value |
| duty_hi_i | input | CNT_W | Compare value for the turn-on edge (and both edges in centred mode) |
| duty_lo_i | input | CNT_W | Compare value for the turn-off edge in dual-compare mode |
| cnt_o | output | CNT_W | Current counter value |
| cnt_up_o | output | 1 | 1 while counting up (including the peak and zero) |
| pwm_hi_o | output | 1 | High-side PWM output |
| pwm_lo_o | output | 1 | Low-side PWM output |

## Verification
The bench goes after compare values changed in the middle of a cycle. A design that did not buffer them would cut a pulse short or put an edge in the wrong place. It drives compare values of 0, equal to the period and above the period. A design without the range check would latch high across cycles or produce a stray edge. It also uses periods of 0, 1 and 2, where a counter that turns at the wrong point underflows or misses its peak. Stopping in the middle of a pulse and restarting is covered too: a design that kept stale state would resume high or resume counting from the old value. In centred mode the low-side compare value is set both to an in-range value and to 0, so a design that used it for the falling edge would show a shifted or missing pulse.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    MODE_DUAL   = 1'b0,
    MODE_CENTER = 1'b1
  } cpwm_mode_e;
endpackage

// File: rtl/cpwm_tri_cnt.sv
module cpwm_tri_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          up_o
);
  logic [CW-1:0] cnt_q;
  logic          up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q >= per_i) begin
        if (per_i == '0) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          up_q  <= (cnt_q == CW'(1));
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      // last step down lands on zero already in the up phase
      cnt_q <= cnt_q - 1'b1;
      up_q  <= (cnt_q == CW'(1));
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;
endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          mode_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] dh_i,
  input  logic [CW-1:0] dl_i,
  output cpwm_mode_e    mode_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] dh_o,
  output logic [CW-1:0] dl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_DUAL;
      per_o  <= '0;
      dh_o   <= '0;
      dl_o   <= '0;
    end else if (load_i) begin
      mode_o <= cpwm_mode_e'(mode_i);
      per_o  <= per_i;
      dh_o   <= dh_i;
      dl_o   <= dl_i;
    end
  end
endmodule

// File: rtl/cpwm_edge.sv
module cpwm_edge
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  cpwm_mode_e    mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          up_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] dh_i,
  input  logic [CW-1:0] dl_i,
  output logic          hi_o
);
  logic          dh_ok, dl_ok, cfg_ok, set_ev, clr_ev;
  logic [CW-1:0] fall_ref;

  always_comb begin
    dh_ok    = (dh_i != '0) && (dh_i < per_i);
    dl_ok    = (dl_i != '0) && (dl_i < per_i);
    cfg_ok   = (mode_i == MODE_CENTER) ? dh_ok : (dh_ok && dl_ok);
    fall_ref = (mode_i == MODE_CENTER) ? dh_i : dl_i;
    set_ev   = up_i && (cnt_i == dh_i);
    clr_ev   = !up_i && (cnt_i == fall_ref);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hi_o <= 1'b0;
    else if (!run_i)      hi_o <= 1'b0;
    else if (!cfg_ok)     hi_o <= 1'b0;
    else if (set_ev)      hi_o <= 1'b1;
    else if (clr_ev)      hi_o <= 1'b0;
  end
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_hi_i,
  input  logic [CNT_W-1:0] duty_lo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_up_o,
  output logic             pwm_hi_o,
  output logic             pwm_lo_o
);
  logic             run_q, load, up;
  logic [CNT_W-1:0] cnt, per_sh, per_use, dh_sh, dl_sh;
  cpwm_mode_e       mode_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= start_i;
  end

  assign load    = (cnt == '0) || !start_i;
  // counter turns on the value being captured this edge
  assign per_use = load ? period_i : per_sh;

  cpwm_shadow #(.CW(CNT_W)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .mode_i (mode_i),
    .per_i  (period_i),
    .dh_i   (duty_hi_i),
    .dl_i   (duty_lo_i),
    .mode_o (mode_sh),
    .per_o  (per_sh),
    .dh_o   (dh_sh),
    .dl_o   (dl_sh)
  );

  cpwm_tri_cnt #(.CW(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (start_i),
    .per_i  (per_use),
    .cnt_o  (cnt),
    .up_o   (up)
  );

  cpwm_edge #(.CW(CNT_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (start_i),
    .mode_i (mode_sh),
    .cnt_i  (cnt),
    .up_i   (up),
    .per_i  (per_sh),
    .dh_i   (dh_sh),
    .dl_i   (dl_sh),
    .hi_o   (pwm_hi_o)
  );

  assign cnt_o    = cnt;
  assign cnt_up_o = up;
  assign pwm_lo_o = run_q & ~pwm_hi_o;
endmodule

// File: rtl/cpwm_pair_chk.sv
module cpwm_pair_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [CW-1:0] cnt_o,
  input logic          cnt_up_o,
  input logic          pwm_hi_o,
  input logic          pwm_lo_o
);
  assert_stop_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (cnt_o == '0) && cnt_up_o && !pwm_hi_o && !pwm_lo_o);

  assert_lo_inverse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pwm_lo_o == !pwm_hi_o));

  assert_zero_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0) |-> !pwm_hi_o);

  assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_o == $past(cnt_o) + 1'b1) || (cnt_o == $past(cnt_o) - 1'b1)
                || (cnt_o == $past(cnt_o)));

  assert_rise_on_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_hi_o) |-> cnt_up_o && (cnt_o != '0));
endmodule

bind cpwm_pair cpwm_pair_chk #(.CW(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .cnt_o    (cnt_o),
  .cnt_up_o (cnt_up_o),
  .pwm_hi_o (pwm_hi_o),
  .pwm_lo_o (pwm_lo_o)
);

// File: tb/tb_cpwm_pair.sv
`timescale 1ns/1ps
module tb_cpwm_pair;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [W-1:0] period_i = '0;
  logic [W-1:0] duty_hi_i = '0;
  logic [W-1:0] duty_lo_i = '0;
  logic [W-1:0] cnt_o;
  logic         cnt_up_o, pwm_hi_o, pwm_lo_o;

  always #4 clk_i = ~clk_i;

  cpwm_pair #(.CNT_W(W)) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .period_i  (period_i),
    .duty_hi_i (duty_hi_i),
    .duty_lo_i (duty_lo_i),
    .cnt_o     (cnt_o),
    .cnt_up_o  (cnt_up_o),
    .pwm_hi_o  (pwm_hi_o),
    .pwm_lo_o  (pwm_lo_o)
  );

  typedef struct {
    int    cnt;
    bit    up;
    bit    hi;
    bit    lo;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string phase = "R1";

  // reference: position t inside a 2P cycle
  int m_t = 0, m_p = 0, m_h = 0, m_l = 0;
  bit m_c = 0, m_run = 0;

  always @(posedge clk_i) begin
    exp_t e;
    int   rise_at, fall_ref;
    bit   ok;
    if (!rst_ni) begin
      m_t = 0; m_run = 0; m_p = 0; m_h = 0; m_l = 0; m_c = 0;
    end else if (!start_i) begin
      m_t = 0; m_run = 0;
      m_p = int'(period_i); m_h = int'(duty_hi_i); m_l = int'(duty_lo_i); m_c = mode_i;
    end else begin
      m_run = 1;
      if (m_t == 0) begin
        m_p = int'(period_i); m_h = int'(duty_hi_i); m_l = int'(duty_lo_i); m_c = mode_i;
      end
      m_t = (m_p == 0) ? 0 : (m_t + 1) % (2 * m_p);
    end
    ok = (m_h >= 1 && m_h < m_p);
    if (!m_c) ok = ok && (m_l >= 1 && m_l < m_p);
    rise_at  = m_h + 1;
    fall_ref = m_c ? m_h : m_l;
    e.cnt = (m_t <= m_p) ? m_t : 2 * m_p - m_t;
    e.up  = (m_t <= m_p);
    e.hi  = m_run && ok && (m_t >= rise_at) && (m_t <= 2 * m_p - fall_ref);
    e.lo  = m_run && !e.hi;
    e.tag = (phase == "ASYM") ? (e.hi ? "R3" : "R4") : phase;
    sb_q.push_back(e);
  end

  always @(negedge clk_i) begin
    exp_t e;
    if (!done && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_cmp++;
      if (int'(cnt_o) != e.cnt || cnt_up_o != e.up) begin
        n_bad++;
        $display("FAIL %s cnt/dir: got %0d/%0b exp %0d/%0b",
                 (e.tag == "R1" || e.tag == "R9") ? e.tag : "R2", cnt_o, cnt_up_o, e.cnt, e.up);
      end
      if (pwm_hi_o != e.hi) begin
        n_bad++;
        $display("FAIL %s pwm_hi: got %0b exp %0b (cnt %0d)", e.tag, pwm_hi_o, e.hi, e.cnt);
      end
      if (pwm_lo_o != e.lo) begin
        n_bad++;
        $display("FAIL R6 pwm_lo: got %0b exp %0b (cnt %0d)", pwm_lo_o, e.lo, e.cnt);
      end
      n_cmp++;
      if (cnt_o == '0 && pwm_hi_o) begin
        n_bad++;
        $display("FAIL R10 hi at zero: got 1 exp 0");
      end
    end
  end

  task automatic drive(input bit st, input bit md, input int p, input int h, input int l,
                       input string tg);
    @(negedge clk_i);
    start_i   = st;
    mode_i    = md;
    period_i  = W'(p);
    duty_hi_i = W'(h);
    duty_lo_i = W'(l);
    phase     = tg;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin
    // R1: reset and idle
    wait_cyc(3);
    @(negedge clk_i) rst_ni = 1'b1;
    wait_cyc(4);
    // R3 / R4: dual-compare, off-centre pulse
    drive(1, 0, 10, 3, 4, "ASYM");
    wait_cyc(65);
    // R7: mid-cycle rewrite of compares and period
    drive(1, 0, 6, 2, 5, "R7");
    wait_cyc(40);
    drive(1, 0, 9, 7, 2, "ASYM");
    wait_cyc(50);
    // R5: centred mode, low compare ignored (in range and zero)
    drive(1, 1, 8, 3, 5, "R5");
    wait_cyc(40);
    drive(1, 1, 8, 5, 0, "R5");
    wait_cyc(40);
    // R8: out-of-range compares
    drive(1, 0, 10, 0, 3, "R8");
    wait_cyc(30);
    drive(1, 0, 10, 10, 3, "R8");
    wait_cyc(30);
    drive(1, 0, 10, 12, 3, "R8");
    wait_cyc(30);
    drive(1, 0, 10, 3, 0, "R8");
    wait_cyc(30);
    drive(1, 1, 10, 0, 4, "R8");
    wait_cyc(30);
    // R9: stop inside a pulse, restart
    drive(1, 1, 8, 2, 0, "R9");
    wait_cyc(12);
    drive(0, 1, 8, 2, 0, "R9");
    wait_cyc(6);
    drive(1, 1, 8, 2, 0, "R9");
    wait_cyc(30);
    // R2: tiny periods
    drive(1, 0, 1, 1, 1, "R2");
    wait_cyc(12);
    drive(1, 0, 0, 1, 1, "R2");
    wait_cyc(12);
    drive(1, 0, 2, 1, 1, "R2");
    wait_cyc(16);
    drive(0, 0, 2, 1, 1, "R9");
    wait_cyc(4);
    summary();
  end
endmodule